// File: doc/BRIEF.md
# Differential PSK Phase Slicer

This block takes a stream of quantized carrier-phase samples and produces, for every accepted sample, a decision on how far the carrier phase has turned since one symbol period earlier. Each sample is an 8-bit angle in which 256 units make a full turn, so every wrap is plain modulo-256 arithmetic. A circular delay line keeps the most recent samples. The block subtracts the sample taken exactly `sym_delay` samples back from the current one, adds a rounding offset to the difference and truncates it to the nearest constellation point. The result is a 2-bit index (four points, 90 degrees apart) or a 3-bit index (eight points, 45 degrees apart). Only the change of phase matters, so the absolute carrier phase has no effect.

The symbol period in samples is the sample rate divided by the symbol rate, rounded. For example, a 2400 bit/s stream is 1200 baud in the four-point mode and 800 baud in the eight-point mode. That period is supplied at run time on `sym_delay`, and the code 0 stands for 64 samples. `sym_delay` is expected to stay constant while a stream is running. `mode_8psk` is sampled together with each accepted phase sample, so the mode can change from one sample to the next.

Both stream edges use valid/ready. An input sample is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. The output holds one result. When that result is not consumed, `in_ready` goes low and the upstream source must hold its sample. A held result stays unchanged until it is consumed.

Top module: `dpsk_phase_slicer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For an accepted sample `cur` with effective delay D (D = `sym_delay`, or 64 when `sym_delay` is 0), the block forms delta = (cur - past) mod 256. Here `past` is the phase of the sample accepted exactly D samples earlier.
- R3: When `mode_8psk` is 0 at acceptance, `out_index[1:0]` = ((delta + 32) mod 256) >> 6 and `out_index[2]` = 0.
- R4: When `mode_8psk` is 1 at acceptance, `out_index[2:0]` = ((delta + 16) mod 256) >> 5.
- R5: The first D samples accepted after reset produce no result, and `out_valid` stays low for them.
- R6: A sample accepted on a clock edge, once at least D samples precede it, makes `out_valid` high after that same edge. While `out_ready` is low, `out_valid` stays high and `out_index` stays unchanged.
- R7: `in_ready` = !`out_valid` || `out_ready`. A sample is stored only on an edge where `in_valid` and `in_ready` are both high.
- R8: Adding the same constant (mod 256) to every input phase leaves every output index unchanged.
- R9: The mode is taken per sample, so samples of different modes may be interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_8psk | input | 1 | 0: four-point decision, 1: eight-point decision; sampled with each accepted sample |
| sym_delay | input | 6 | Symbol period in samples, 1..63; 0 means 64 |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_phase | input | 8 | Phase angle, 256 units per turn |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_index | output | 3 | Phase-shift index |

## Verification
The bench drives deltas right on both sides of each rounding threshold: 31/32 and 223/224 in the four-point mode, and 15/16 and 239/240 in the eight-point mode. A design with the wrong offset or shift, or one that drops the modulo wrap, gives a neighbouring index there. It checks that nothing appears before the delay line holds D samples, and that delay code 0 reaches 64 samples back. An off-by-one read pointer or fill test shows up as early results or mismatched indices. Random back-pressure and gaps in `in_valid` catch a design that stores unaccepted samples or changes a held result. Finally, a sequence is run twice with a constant phase offset to show that only differences matter.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;

  localparam int PHASE_W = 8;
  localparam int INDEX_W = 3;

  typedef enum logic {
    DEC_FOUR  = 1'b0,
    DEC_EIGHT = 1'b1
  } dec_mode_e;

  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [INDEX_W-1:0] index_t;

endpackage

// File: rtl/dpsk_delay_line.sv
module dpsk_delay_line #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               din,
  input  logic [$clog2(DEPTH)-1:0]   dly,
  output logic [W-1:0]               dout,
  output logic                       filled
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [CW-1:0] fill_cnt;
  logic [CW-1:0] dly_eff;
  logic [AW-1:0] rd_ptr;

  // delay code 0 wraps to a full turn of the pointer, i.e. DEPTH samples
  assign dly_eff = (dly == '0) ? FULL : {1'b0, dly};
  assign rd_ptr  = wr_ptr - dly;
  assign dout    = mem[rd_ptr];
  assign filled  = (fill_cnt >= dly_eff);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      fill_cnt <= '0;
    end else if (wr_en) begin
      wr_ptr <= wr_ptr + 1'b1;
      if (fill_cnt != FULL) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  // R2: each stored sample moves the write pointer by exactly one slot
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_ptr == $past(wr_ptr) + 1'b1));

  // R7: without a store the pointer and fill level stay put
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(wr_ptr) && $stable(fill_cnt)));

endmodule

// File: rtl/dpsk_decide.sv
module dpsk_decide
  import dpsk_pkg::*;
(
  input  phase_t    cur,
  input  phase_t    past,
  input  dec_mode_e mode,
  output index_t    index
);
  localparam int FOUR_SH  = PHASE_W - 2;
  localparam int EIGHT_SH = PHASE_W - 3;

  phase_t delta;
  phase_t rnd_four;
  phase_t rnd_eight;

  assign delta     = cur - past;
  assign rnd_four  = delta + phase_t'(1 << (FOUR_SH - 1));
  assign rnd_eight = delta + phase_t'(1 << (EIGHT_SH - 1));

  always_comb begin
    if (mode == DEC_EIGHT) index = rnd_eight[PHASE_W-1 -: 3];
    else                   index = {1'b0, rnd_four[PHASE_W-1 -: 2]};
  end

  // R3: four-point decisions never set the top index bit
  always_comb begin
    if (mode == DEC_FOUR) a_four_top_r3: assert (index[2] == 1'b0);
  end

endmodule

// File: rtl/dpsk_out_stage.sv
module dpsk_out_stage
  import dpsk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  index_t din,
  input  logic   out_ready,
  output logic   out_valid,
  output index_t out_index
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_index <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_index <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6: a stalled result is held unchanged
  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index)));

  // R6: a load shows up after the very next edge
  p_load_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);

endmodule

// File: rtl/dpsk_phase_slicer.sv
module dpsk_phase_slicer
  import dpsk_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_8psk,
  input  logic [5:0] sym_delay,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_phase,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [2:0] out_index
);
  localparam int AW = $clog2(DEPTH);

  logic   accept;
  logic   filled;
  phase_t past_phase;
  index_t dec_index;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  dpsk_delay_line #(.DEPTH(DEPTH), .W(PHASE_W)) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (accept),
    .din    (in_phase),
    .dly    (AW'(sym_delay)),
    .dout   (past_phase),
    .filled (filled)
  );

  dpsk_decide u_decide (
    .cur   (in_phase),
    .past  (past_phase),
    .mode  (dec_mode_e'(mode_8psk)),
    .index (dec_index)
  );

  dpsk_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && filled),
    .din       (dec_index),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_index (out_index)
  );

  // R5: a sample accepted before the line is filled yields nothing new
  p_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !filled && (!out_valid || out_ready)) |=> !out_valid);

  // R7: an idle output always admits input
  p_ready_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

// File: tb/dpsk_phase_slicer_test.sv
module dpsk_phase_slicer_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       mode_8psk = 0;
  logic [5:0] sym_delay = 6'd1;
  logic       in_valid = 0;
  logic       in_ready;
  logic [7:0] in_phase = 0;
  logic       out_valid;
  logic       out_ready = 0;
  logic [2:0] out_index;

  int errors = 0;
  int checks = 0;
  int hist [8192];
  int n_acc = 0;
  int expq [$];
  string tagq [$];
  int rec [256];
  int nrec = 0;
  int rec_a [256];
  int nrec_a = 0;
  bit stall_prev = 0;
  int stall_idx = 0;
  bit load_prev = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dpsk_phase_slicer uut (
    .clk(clk), .rst_n(rst_n), .mode_8psk(mode_8psk), .sym_delay(sym_delay),
    .in_valid(in_valid), .in_ready(in_ready), .in_phase(in_phase),
    .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index)
  );

  function automatic int exp_idx(int cur, int past, bit m);
    int d;
    d = (cur - past) & 255;
    if (m) return ((d + 16) & 255) >> 5;
    return ((d + 32) & 255) >> 6;
  endfunction

  function automatic int deff();
    return (sym_delay == 0) ? 64 : int'(sym_delay);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset(int d);
    @(negedge clk);
    rst_n = 0; in_valid = 0; out_ready = 0; sym_delay = 6'(d);
    n_acc = 0; expq.delete(); tagq.delete(); nrec = 0;
    stall_prev = 0; load_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic step(bit v, int ph, bit m, bit rdy);
    bit acc;
    @(negedge clk);
    in_valid = v; in_phase = 8'(ph); mode_8psk = m; out_ready = rdy;
    #1;
    if (stall_prev)
      chk(out_valid && out_index == 3'(stall_idx), "R6 held result", out_index, stall_idx);
    if (load_prev)
      chk(out_valid == 1, "R6 result after accept", out_valid, 1);
    chk(in_ready == (!out_valid || out_ready), "R7 ready rule", in_ready, !out_valid || out_ready);
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(0, "R5 unexpected result", out_index, -1);
      else begin
        chk(out_index == 3'(expq[0]), tagq[0], out_index, expq[0]);
        void'(expq.pop_front()); void'(tagq.pop_front());
        if (nrec < 256) begin rec[nrec] = out_index; nrec++; end
      end
    end
    stall_prev = out_valid && !out_ready;
    stall_idx = out_index;
    acc = v && in_ready;
    load_prev = 0;
    if (acc) begin
      hist[n_acc] = ph & 255;
      if (n_acc >= deff()) begin
        expq.push_back(exp_idx(ph & 255, hist[n_acc - deff()], m));
        tagq.push_back(m ? "R2 R4 R9 eight-point index" : "R2 R3 R9 four-point index");
        load_prev = 1;
      end
      n_acc++;
    end
  endtask

  task automatic run_deltas(int start, bit m);
    int dl [7];
    int ph;
    dl = '{31, 32, 223, 224, 15, 16, 240};
    if (m) dl = '{15, 16, 239, 240, 47, 48, 0};
    ph = start;
    step(1, ph, m, 1);
    foreach (dl[i]) begin ph = ph + dl[i]; step(1, ph, m, 1); end
    step(0, 0, m, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset(1);
    run_deltas(0, 0);
    run_deltas(0, 1);

    // R8: same deltas, constant offset
    do_reset(1);
    run_deltas(0, 0); run_deltas(0, 1);
    nrec_a = nrec;
    for (int i = 0; i < nrec; i++) rec_a[i] = rec[i];
    do_reset(1);
    run_deltas(77, 0); run_deltas(77, 1);
    chk(nrec == nrec_a, "R8 result count", nrec, nrec_a);
    for (int i = 0; i < nrec && i < nrec_a; i++)
      chk(rec[i] == rec_a[i], "R8 offset invariance", rec[i], rec_a[i]);

    // R5: nothing before the line holds D samples
    do_reset(5);
    for (int i = 0; i < 5; i++) begin
      step(1, $urandom_range(0, 255), 0, 1);
      chk(expq.size() == 0 && out_valid == 0, "R5 early output", out_valid, 0);
    end
    step(1, 200, 1, 1);
    step(0, 0, 0, 1);
    chk(load_prev == 0 && nrec == 1, "R5 first result count", nrec, 1);

    // delay code 0 means 64 samples
    do_reset(0);
    for (int i = 0; i < 150; i++) step(1, $urandom_range(0, 255), 1'($urandom), 1);
    step(0, 0, 0, 1);

    // random stream with gaps and back-pressure
    do_reset(7);
    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(0, 3) != 0), $urandom_range(0, 255), 1'($urandom),
           1'($urandom_range(0, 2) != 0));
    do_reset(3);
    for (int i = 0; i < 2000; i++)
      step(1'($urandom), $urandom_range(0, 255), 1'($urandom), 1'($urandom));
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
    chk(expq.size() == 0, "R6 pending results drained", expq.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule